// File: doc/BRIEF.md
# Eight-Channel Converter Scan Sequencer

This block controls an external 8-bit analog-to-digital converter that has eight single-ended inputs and a parallel bus. For every channel it places the 3-bit channel number on the address lines, latches it, starts a conversion and waits for the converter's end-of-conversion line to fall and then rise again. It then enables the converter's output driver for two cycles, takes the byte on the second cycle, and moves on to the next channel. It also divides the system clock to produce the converter's 600 kHz conversion clock.

After the last channel the eight bytes are packed into one 64-bit word for a downstream cipher stage. The word is offered with a valid/ready handshake and does not change until it is taken. Only then does a new scan begin. If the converter fails to finish a conversion within a programmable number of conversion-clock periods, the sequencer abandons the scan, raises a one-cycle error pulse and starts again from channel 0.

Top module: `adc_scan_ctrl`

## Requirements
- R1: A synchronous active-high reset returns the block to idle. On the clock edge where `rst` is high, `adc_ale`, `adc_start`, `adc_oe`, `blk_valid`, `err_timeout` and `adc_clk` become 0 and `adc_addr` becomes 0. After reset is released, a fresh scan from channel 0 yields a correct word.
- R2: `adc_clk` is a square wave with a period of 2·⌊SYS_CLK_HZ/(2·CONV_CLK_HZ)⌋ system cycles. At the defaults (100 MHz, 600 kHz) this is 166 cycles, with 83 cycles high.
- R3: For each channel the sequence runs as follows. The address is driven. `adc_ale` is high for one cycle and `adc_start` is high in the next cycle. The sequencer waits for the synchronised `adc_eoc` to go low and then high. `adc_oe` is then high for exactly two cycles, and the byte is taken on the second of them. A full scan therefore holds `adc_oe` high for 16 cycles.
- R4: Channels are scanned in ascending order 0 to 7, with one `adc_ale` pulse per channel. `adc_addr` does not change in the cycle where `adc_ale` is high.
- R5: The byte from channel k appears in `blk_data[8k+7:8k]`, so channel 0 occupies bits [7:0].
- R6: `blk_valid` rises after channel 7 has been captured. While `blk_ready` is low, `blk_valid` stays high and `blk_data` stays stable. After a cycle in which both are high, `blk_valid` is low.
- R7: While `blk_valid` is high, `adc_ale`, `adc_start` and `adc_oe` stay low. The next scan starts at channel 0 only after the handshake.
- R8: The sequencer may wait for end-of-conversion through `timeout_limit` rising edges of the conversion clock. When that limit is reached, `err_timeout` is high for one cycle and `blk_valid` stays low. The scan is dropped and a new scan starts at channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| timeout_limit | input | TO_W | Conversion-clock periods allowed while waiting for end-of-conversion |
| adc_eoc | input | 1 | Converter end-of-conversion, low while busy |
| adc_data | input | SAMPLE_W | Converter output byte |
| blk_ready | input | 1 | Consumer accepts the packed word |
| adc_clk | output | 1 | Divided conversion clock |
| adc_addr | output | log2(CH_NUM) | Channel select |
| adc_ale | output | 1 | Address latch strobe |
| adc_start | output | 1 | Conversion start strobe |
| adc_oe | output | 1 | Converter output enable |
| blk_data | output | SAMPLE_W·CH_NUM | Packed samples, channel 0 in the low byte |
| blk_valid | output | 1 | Packed word available |
| err_timeout | output | 1 | One-cycle pulse on a conversion timeout |

## Verification
Two events can fall in the same cycle: the release of a finished word and the launch of the next scan. When `blk_ready` is already high in the first cycle of `blk_valid`, the hold state and the sequencer's restart are only one edge apart. The bench provokes this with a vector whose ready delay is zero. It then judges that the word matched and that `blk_valid` fell on the next edge. It also requires that no latch or start strobe appeared while the word was offered, and that the following scan again walks the addresses 0 to 7 from the start.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
package adc_scan_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_ADDR    = 4'd1,
        ST_LATCH   = 4'd2,
        ST_START   = 4'd3,
        ST_WAIT_LO = 4'd4,
        ST_WAIT_HI = 4'd5,
        ST_OE      = 4'd6,
        ST_CAPT    = 4'd7,
        ST_REL     = 4'd8,
        ST_HOLD    = 4'd9
    } scan_state_e;

endpackage

// File: rtl/adc_clk_div.sv
`timescale 1ns/1ps
module adc_clk_div #(
    parameter int HALF = 83
) (
    input  logic clk,
    input  logic rst,
    output logic conv_clk,
    output logic rise_tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d     = div_q;
        rise_tick = 1'b0;
        if (div_q.cnt == CW'(HALF - 1)) begin
            div_d.cnt = '0;
            div_d.lvl = ~div_q.lvl;
            rise_tick = ~div_q.lvl;
        end else begin
            div_d.cnt = div_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_d;
    end

    assign conv_clk = div_q.lvl;
endmodule

// File: rtl/adc_eoc_sync.sv
`timescale 1ns/1ps
module adc_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/adc_lane_pack.sv
`timescale 1ns/1ps
module adc_lane_pack #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [LANE_W-1:0]       wr_byte,
    output logic [LANES*LANE_W-1:0] word
);
    logic [LANES*LANE_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        for (int l = 0; l < LANES; l++) begin
            if (wr_en && (wr_sel == SEL_W'(l)))
                word_d[l*LANE_W +: LANE_W] = wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign word = word_q;
endmodule

// File: rtl/adc_scan_fsm.sv
`timescale 1ns/1ps
module adc_scan_fsm
    import adc_scan_pkg::*;
#(
    parameter int CH_NUM = 8,
    parameter int CH_W   = 3,
    parameter int TO_W   = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            eoc_s,
    input  logic [TO_W-1:0] limit,
    input  logic            ready,
    output logic [CH_W-1:0] addr,
    output logic            ale,
    output logic            start,
    output logic            oe,
    output logic            cap_en,
    output logic            valid,
    output logic            err
);
    typedef struct packed {
        scan_state_e     st;
        logic [CH_W-1:0] ch;
        logic [TO_W-1:0] tmo;
        logic            err;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [TO_W:0] tmo_nx;
    logic          expire;

    always_comb begin
        seq_d     = seq_q;
        seq_d.err = 1'b0;
        tmo_nx    = {1'b0, seq_q.tmo} + (TO_W + 1)'(1);
        expire    = tick && (tmo_nx >= {1'b0, limit});

        case (seq_q.st)
            ST_IDLE: begin
                seq_d.ch = '0;
                seq_d.st = ST_ADDR;
            end
            ST_ADDR:  seq_d.st = ST_LATCH;
            ST_LATCH: seq_d.st = ST_START;
            ST_START: begin
                seq_d.tmo = '0;
                seq_d.st  = ST_WAIT_LO;
            end
            ST_WAIT_LO, ST_WAIT_HI: begin
                if (tick && (seq_q.tmo != '1))
                    seq_d.tmo = tmo_nx[TO_W-1:0];
                if (seq_q.st == ST_WAIT_LO && !eoc_s) begin
                    seq_d.st = ST_WAIT_HI;
                end else if (seq_q.st == ST_WAIT_HI && eoc_s) begin
                    seq_d.st = ST_OE;
                end else if (expire) begin
                    seq_d.st  = ST_IDLE;
                    seq_d.err = 1'b1;
                end
            end
            ST_OE:   seq_d.st = ST_CAPT;
            ST_CAPT: seq_d.st = ST_REL;
            ST_REL: begin
                if (seq_q.ch == CH_W'(CH_NUM - 1)) begin
                    seq_d.st = ST_HOLD;
                end else begin
                    seq_d.ch = seq_q.ch + CH_W'(1);
                    seq_d.st = ST_ADDR;
                end
            end
            ST_HOLD: if (ready) seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign addr   = seq_q.ch;
    assign ale    = (seq_q.st == ST_LATCH);
    assign start  = (seq_q.st == ST_START);
    assign oe     = (seq_q.st == ST_OE) || (seq_q.st == ST_CAPT);
    assign cap_en = (seq_q.st == ST_CAPT);
    assign valid  = (seq_q.st == ST_HOLD);
    assign err    = seq_q.err;
endmodule

// File: rtl/adc_scan_ctrl.sv
`timescale 1ns/1ps
module adc_scan_ctrl #(
    parameter int SYS_CLK_HZ  = 100_000_000,
    parameter int CONV_CLK_HZ = 600_000,
    parameter int SAMPLE_W    = 8,
    parameter int CH_NUM      = 8,
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [TO_W-1:0]              timeout_limit,
    input  logic                         adc_eoc,
    input  logic [SAMPLE_W-1:0]          adc_data,
    input  logic                         blk_ready,
    output logic                         adc_clk,
    output logic [$clog2(CH_NUM)-1:0]    adc_addr,
    output logic                         adc_ale,
    output logic                         adc_start,
    output logic                         adc_oe,
    output logic [SAMPLE_W*CH_NUM-1:0]   blk_data,
    output logic                         blk_valid,
    output logic                         err_timeout
);
    localparam int CH_W  = $clog2(CH_NUM);
    localparam int BLK_W = SAMPLE_W * CH_NUM;
    localparam int HALF  = SYS_CLK_HZ / (2 * CONV_CLK_HZ);

    logic tick, eoc_s, cap_en;

    adc_clk_div #(.HALF(HALF)) i_div (
        .clk       (clk),
        .rst       (rst),
        .conv_clk  (adc_clk),
        .rise_tick (tick)
    );

    adc_eoc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (adc_eoc),
        .dout (eoc_s)
    );

    adc_scan_fsm #(.CH_NUM(CH_NUM), .CH_W(CH_W), .TO_W(TO_W)) i_fsm (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .eoc_s  (eoc_s),
        .limit  (timeout_limit),
        .ready  (blk_ready),
        .addr   (adc_addr),
        .ale    (adc_ale),
        .start  (adc_start),
        .oe     (adc_oe),
        .cap_en (cap_en),
        .valid  (blk_valid),
        .err    (err_timeout)
    );

    adc_lane_pack #(.LANES(CH_NUM), .LANE_W(SAMPLE_W), .SEL_W(CH_W)) i_pack (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cap_en),
        .wr_sel  (adc_addr),
        .wr_byte (adc_data),
        .word    (blk_data)
    );

    logic [BLK_W-1:0] unused_w;
    assign unused_w = blk_data;
endmodule

// File: rtl/adc_scan_chk.sv
`timescale 1ns/1ps
module adc_scan_chk #(
    parameter int ADDR_W = 3,
    parameter int BLK_W  = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              ale,
    input logic              start,
    input logic              oe,
    input logic              eoc,
    input logic [ADDR_W-1:0] addr,
    input logic              valid,
    input logic              ready,
    input logic [BLK_W-1:0]  data,
    input logic              err
);
    // R3
    ale_then_start_chk: assert property (@(posedge clk) disable iff (rst)
        ale |=> start && !ale);
    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !start && !ale);
    // R3
    oe_after_eoc_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> eoc);
    // R3
    oe_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |=> oe ##1 !oe);
    // R4
    addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
        ale |-> $stable(addr));
    // R6
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(data));
    // R6
    word_release_chk: assert property (@(posedge clk) disable iff (rst)
        valid && ready |=> !valid);
    // R7
    quiet_while_valid_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> !ale && !start && !oe);
    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);
    // R8
    err_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !valid);
endmodule

bind adc_scan_ctrl adc_scan_chk #(.ADDR_W(CH_W), .BLK_W(BLK_W)) i_chk (
    .clk   (clk),
    .rst   (rst),
    .ale   (adc_ale),
    .start (adc_start),
    .oe    (adc_oe),
    .eoc   (adc_eoc),
    .addr  (adc_addr),
    .valid (blk_valid),
    .ready (blk_ready),
    .data  (blk_data),
    .err   (err_timeout)
);

// File: tb/test_adc_scan_ctrl.sv
`timescale 1ns/1ps
module test_adc_scan_ctrl;
    localparam int N_VEC = 4;
    localparam logic [63:0] VEC_WORD [N_VEC] = '{
        64'h8877665544332211, 64'h0102040810204080,
        64'hF0E1D2C3B4A59687, 64'h7F80FE01AA55C33C };
    localparam int VEC_D1 [N_VEC] = '{2, 1, 6, 3};
    localparam int VEC_D2 [N_VEC] = '{3, 1, 9, 25};
    localparam int VEC_RW [N_VEC] = '{0, 5, 17, 1};

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] tlim;
    logic        eoc;
    logic [7:0]  adc_data;
    logic        blk_ready;
    logic        adc_clk, adc_ale, adc_start, adc_oe, blk_valid, err_timeout;
    logic [2:0]  adc_addr;
    logic [63:0] blk_data;

    adc_scan_ctrl i_adc_scan_ctrl (
        .clk (clk), .rst (rst), .timeout_limit (tlim), .adc_eoc (eoc),
        .adc_data (adc_data), .blk_ready (blk_ready), .adc_clk (adc_clk),
        .adc_addr (adc_addr), .adc_ale (adc_ale), .adc_start (adc_start),
        .adc_oe (adc_oe), .blk_data (blk_data), .blk_valid (blk_valid),
        .err_timeout (err_timeout)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // converter model
    logic [2:0]  lat_addr = 3'd0;
    logic [63:0] cur_word;
    int d1, d2;
    bit mute = 0;
    assign adc_data = adc_oe ? cur_word[lat_addr*8 +: 8] : 8'h00;

    initial begin
        forever begin
            @(negedge clk);
            if (adc_ale) lat_addr = adc_addr;
            if (adc_start) begin
                if (mute) eoc = 1'b0;
                else begin
                    repeat (d1) @(negedge clk);
                    eoc = 1'b0;
                    repeat (d2) @(negedge clk);
                    eoc = 1'b1;
                end
            end
        end
    end

    // port monitor
    logic [2:0] addr_log [16];
    int n_addr = 0, oe_cyc = 0, quiet_bad = 0;
    realtime t_start = 0.0;
    always @(negedge clk) begin
        if (adc_ale && n_addr < 16) begin
            addr_log[n_addr] = adc_addr;
            n_addr++;
        end
        if (blk_valid && (adc_ale || adc_start || adc_oe)) quiet_bad++;
        if (adc_oe) oe_cyc++;
        if (adc_start) t_start = $realtime;
    end

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        end
    endtask

    task automatic scan_and_take(input logic [63:0] word, input int rw, input string tag);
        bit got = 0;
        bit steady = 1;
        logic [23:0] seq_act, seq_exp;
        logic [63:0] held;
        for (int i = 0; i < 20000 && !got; i++) begin
            @(negedge clk);
            got = blk_valid;
        end
        check(got, {"R6 valid rises ", tag}, 64'(got), 64'd1);
        check(blk_data == word, {"R5 lane packing ", tag}, blk_data, word);
        seq_act = '0;
        seq_exp = '0;
        for (int k = 0; k < 8; k++) begin
            seq_exp[3*k +: 3] = 3'(k);
            if (k < n_addr) seq_act[3*k +: 3] = addr_log[k];
        end
        check(n_addr == 8 && seq_act == seq_exp, {"R4 address order ", tag},
              {32'(n_addr), 8'h0, seq_act}, {32'd8, 8'h0, seq_exp});
        check(oe_cyc == 16, {"R3 oe cycles ", tag}, 64'(oe_cyc), 64'd16);
        held = blk_data;
        for (int i = 0; i < rw; i++) begin
            @(negedge clk);
            if (!blk_valid || blk_data != held) steady = 0;
        end
        check(steady, {"R6 hold while not ready ", tag}, 64'(steady), 64'd1);
        blk_ready = 1'b1;
        @(negedge clk);
        blk_ready = 1'b0;
        check(!blk_valid, {"R6 valid drops after handshake ", tag}, 64'(blk_valid), 64'd0);
        check(quiet_bad == 0, {"R7 no strobes while valid ", tag}, 64'(quiet_bad), 64'd0);
        n_addr = 0;
        oe_cyc = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        realtime t0, t1, t2, t_err;
        bit seen;
        logic [63:0] w5, w6;
        rst = 1'b1; blk_ready = 1'b0; eoc = 1'b1; tlim = 16'd50;
        cur_word = VEC_WORD[0]; d1 = VEC_D1[0]; d2 = VEC_D2[0];
        repeat (3) @(negedge clk);
        // R1 reset state
        check({adc_ale, adc_start, adc_oe, blk_valid, err_timeout, adc_clk, adc_addr} == 9'd0,
              "R1 reset outputs",
              64'({adc_ale, adc_start, adc_oe, blk_valid, err_timeout, adc_clk, adc_addr}), 64'd0);
        rst = 1'b0;

        // R2 conversion clock period
        @(posedge adc_clk); t0 = $realtime;
        @(negedge adc_clk); t1 = $realtime;
        @(posedge adc_clk); t2 = $realtime;
        check((t2 - t0) > 1659.0 && (t2 - t0) < 1661.0, "R2 adc_clk period",
              64'(int'(t2 - t0)), 64'd1660);
        check((t1 - t0) > 829.0 && (t1 - t0) < 831.0, "R2 adc_clk high time",
              64'(int'(t1 - t0)), 64'd830);
        @(negedge clk);

        // vector table
        for (int v = 0; v < N_VEC; v++) begin
            scan_and_take(VEC_WORD[v], VEC_RW[v], $sformatf("vec%0d", v));
            if (v + 1 < N_VEC) begin
                cur_word = VEC_WORD[v+1]; d1 = VEC_D1[v+1]; d2 = VEC_D2[v+1];
            end
        end

        // R8 timeout: converter never finishes
        mute = 1; tlim = 16'd3;
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            seen = err_timeout;
        end
        t_err = $realtime;
        check(seen, "R8 error raised", 64'(seen), 64'd1);
        check((t_err - t_start) > 3300.0 && (t_err - t_start) < 5100.0, "R8 timeout latency",
              64'(int'(t_err - t_start)), 64'd4150);
        check(!blk_valid, "R8 no word on timeout", 64'(blk_valid), 64'd0);
        mute = 0; eoc = 1'b1; tlim = 16'd50; n_addr = 0; oe_cyc = 0;
        w5 = 64'h13579BDF2468ACE0; cur_word = w5; d1 = 2; d2 = 2;
        @(negedge clk);
        check(!err_timeout, "R8 error is a single pulse", 64'(err_timeout), 64'd0);
        scan_and_take(w5, 3, "r8_restart");

        // R1 reset in the middle of a scan
        w6 = 64'hA1B2C3D4E5F60718; cur_word = w6;
        seen = 0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            seen = adc_oe;
        end
        rst = 1'b1;
        @(negedge clk);
        check({adc_ale, adc_start, adc_oe, blk_valid, err_timeout, adc_clk, adc_addr} == 9'd0,
              "R1 mid-scan reset outputs",
              64'({adc_ale, adc_start, adc_oe, blk_valid, err_timeout, adc_clk, adc_addr}), 64'd0);
        n_addr = 0; oe_cyc = 0;
        rst = 1'b0;
        scan_and_take(w6, 2, "r1_after_reset");

        summary();
        $finish;
    end
endmodule